// File: doc/BRIEF.md
# Windowed Memory Traffic Throttler

This block sits on the command path between a memory controller's scheduler and the DRAM interface and caps average DRAM power by enforcing a duty cycle. Time is cut into fixed windows of `WINDOW_LEN` cycles (10,000 by default). In each window the first part passes commands and the last `T` cycles are a stall, during which no command is offered downstream and none is accepted from upstream. The block decides between stall and pass every cycle.

The stall length `T` comes from the `delay_in` input, which a separate delay estimator drives. The block reads it only at coarse epoch boundaries. A free-running epoch counter of `EPOCH_LEN` cycles (1,000,000 by default) pulses `epoch_tick` once per epoch. The first window boundary after a tick loads a new `T`, so a window is never split between two delays. After reset the first window boundary also loads `T`. Until then `T` is zero.

The control is a two-state machine, `ST_PASS` and `ST_HOLD`, with four named transitions. `KEEP_PASS` leaves it in `ST_PASS`. `START_HOLD` moves `ST_PASS` to `ST_HOLD` when the window position reaches `WINDOW_LEN - T`. `KEEP_HOLD` leaves it in `ST_HOLD` until the window ends. `END_HOLD` moves `ST_HOLD` back to `ST_PASS` at the wrap.

Top module: `mem_throttle_gate`

## Requirements
- R1: While reset is held, and in the cycle it is released, `stall_o` and `epoch_tick` are 0. The first window after reset runs with `T = 0`, so it has no stall.
- R2: Number the cycles after reset release as n = 0, 1, 2, … The window position is n mod `WINDOW_LEN`. `stall_o` is 1 exactly when that position is at least `WINDOW_LEN - T`, so the stall fills the last `T` cycles of each window.
- R3: `T` changes only at a window boundary, in the cycle whose position is `WINDOW_LEN-1`. It changes there only when an epoch tick has occurred since the last load, counting a tick in that same cycle. Reset also arms a load. The value loaded is `delay_in` sampled in that cycle. In every other cycle, changes on `delay_in` have no effect on `stall_o`.
- R4: A `delay_in` value of `WINDOW_LEN` or more loads `WINDOW_LEN-1`. Every window therefore starts with at least one pass cycle.
- R5: While `stall_o` is 1, `dn_valid` and `up_ready` are both 0.
- R6: While `stall_o` is 0, `dn_valid` equals `up_valid` and `up_ready` equals `dn_ready`. `dn_cmd` always equals `up_cmd`.
- R7: `epoch_tick` is 1 for exactly one cycle when n mod `EPOCH_LEN` equals `EPOCH_LEN-1`, and is 0 otherwise.
- R8: With `T = 0`, `stall_o` stays 0 for the whole window.
- R9: No command is lost or duplicated. Each cycle an upstream transfer (`up_valid & up_ready`) happens if and only if a downstream transfer (`dn_valid & dn_ready`) happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| delay_in | input | DLY_W | Requested stall length per window, sampled at epoch-armed window boundaries |
| up_valid | input | 1 | Command offered by the scheduler |
| up_ready | output | 1 | Command accepted from the scheduler |
| up_cmd | input | CMD_W | Command payload from the scheduler |
| dn_valid | output | 1 | Command offered to DRAM |
| dn_ready | input | 1 | DRAM side can take a command |
| dn_cmd | output | CMD_W | Command payload to DRAM |
| stall_o | output | 1 | High during the stall part of a window |
| epoch_tick | output | 1 | One-cycle pulse at each epoch end |

## Verification
The gating outputs `dn_valid`, `up_ready` and `dn_cmd` follow the upstream and downstream inputs in the same cycle. `stall_o` and `epoch_tick` are registered, and each reflects the cycle count one edge after that count is reached. A `delay_in` value sampled in a window's last cycle is first visible in `stall_o` one edge later, inside the next window. The bench holds a cycle-accurate model that advances once per clock. Between falling edges it compares every output against the model for the current cycle. It then steps the model using the inputs of that cycle, and only after that drives new inputs.

// File: rtl/thr_pkg.sv
package thr_pkg;

    typedef enum logic [0:0] {
        ST_PASS = 1'b0,
        ST_HOLD = 1'b1
    } thr_state_e;

endpackage

// File: rtl/thr_window_ctr.sv
module thr_window_ctr #(
    parameter int WINDOW_LEN = 10000,
    localparam int WCNT_W = $clog2(WINDOW_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [WCNT_W-1:0] wpos,
    output logic              wlast
);

    localparam logic [WCNT_W-1:0] LAST_POS = WCNT_W'(WINDOW_LEN - 1);

    assign wlast = (wpos == LAST_POS);

    always_ff @(posedge clk) begin
        if (!rst_n)      wpos <= '0;
        else if (wlast)  wpos <= '0;
        else             wpos <= wpos + 1'b1;
    end

    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wlast |=> (wpos == '0));

    assert_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wpos <= LAST_POS);

endmodule

// File: rtl/thr_epoch_ctr.sv
module thr_epoch_ctr #(
    parameter int EPOCH_LEN = 1000000,
    localparam int ECNT_W = $clog2(EPOCH_LEN)
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam logic [ECNT_W-1:0] LAST_POS = ECNT_W'(EPOCH_LEN - 1);

    logic [ECNT_W-1:0] epos;

    assign tick = rst_n && (epos == LAST_POS);

    always_ff @(posedge clk) begin
        if (!rst_n)                 epos <= '0;
        else if (epos == LAST_POS)  epos <= '0;
        else                        epos <= epos + 1'b1;
    end

    assert_tick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/thr_phase_fsm.sv
module thr_phase_fsm
    import thr_pkg::*;
#(
    parameter int WINDOW_LEN = 10000,
    parameter int DLY_W = 16,
    localparam int WCNT_W = $clog2(WINDOW_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WCNT_W-1:0] wpos,
    input  logic              wlast,
    input  logic              etick,
    input  logic [DLY_W-1:0]  delay_in,
    output logic              stall
);

    localparam int SUM_W = WCNT_W + 1;
    localparam logic [SUM_W-1:0] WIN_S = SUM_W'(WINDOW_LEN);
    localparam logic [WCNT_W-1:0] T_MAX = WCNT_W'(WINDOW_LEN - 1);

    typedef enum logic [1:0] {
        KEEP_PASS,
        START_HOLD,
        KEEP_HOLD,
        END_HOLD
    } thr_move_e;

    thr_state_e        state_q, state_d;
    thr_move_e         move;
    logic [WCNT_W-1:0] t_q, t_d;
    logic              pend_q, pend_d;
    logic              load;
    logic [WCNT_W-1:0] t_clamped;
    logic [WCNT_W-1:0] nxt_pos;
    logic              nxt_in_hold;

    // clamp so each window keeps one pass cycle
    always_comb begin
        if (delay_in >= DLY_W'(WINDOW_LEN)) t_clamped = T_MAX;
        else                                t_clamped = WCNT_W'(delay_in);
    end

    assign load    = wlast && (pend_q || etick);
    assign t_d     = load ? t_clamped : t_q;
    assign pend_d  = load ? 1'b0 : (pend_q || etick);
    assign nxt_pos = wlast ? '0 : wpos + 1'b1;
    assign nxt_in_hold = ({1'b0, nxt_pos} + {1'b0, t_d}) >= WIN_S;

    always_comb begin
        unique case (state_q)
            ST_PASS: move = nxt_in_hold ? START_HOLD : KEEP_PASS;
            ST_HOLD: move = nxt_in_hold ? KEEP_HOLD : END_HOLD;
            default: move = KEEP_PASS;
        endcase
    end

    always_comb begin
        unique case (move)
            START_HOLD, KEEP_HOLD: state_d = ST_HOLD;
            KEEP_PASS, END_HOLD:   state_d = ST_PASS;
            default:               state_d = ST_PASS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PASS;
            t_q     <= '0;
            pend_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            t_q     <= t_d;
            pend_q  <= pend_d;
        end
    end

    always_comb begin
        stall = (state_q == ST_HOLD);
    end

    assert_t_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(t_q));

    assert_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        t_q <= T_MAX);

    assert_window_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wlast |=> (state_q == ST_PASS));

    assert_hold_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !wlast) |=> (state_q == ST_HOLD));

    assert_zero_no_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q == '0 && !load) |=> (state_q == ST_PASS));

endmodule

// File: rtl/mem_throttle_gate.sv
module mem_throttle_gate #(
    parameter int WINDOW_LEN = 10000,
    parameter int EPOCH_LEN  = 1000000,
    parameter int DLY_W      = 16,
    parameter int CMD_W      = 32,
    localparam int WCNT_W    = $clog2(WINDOW_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DLY_W-1:0] delay_in,
    input  logic             up_valid,
    output logic             up_ready,
    input  logic [CMD_W-1:0] up_cmd,
    output logic             dn_valid,
    input  logic             dn_ready,
    output logic [CMD_W-1:0] dn_cmd,
    output logic             stall_o,
    output logic             epoch_tick
);

    logic [WCNT_W-1:0] wpos;
    logic              wlast;
    logic              etick;
    logic              stall;

    thr_window_ctr #(.WINDOW_LEN(WINDOW_LEN)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .wpos  (wpos),
        .wlast (wlast)
    );

    thr_epoch_ctr #(.EPOCH_LEN(EPOCH_LEN)) u_epoch (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (etick)
    );

    thr_phase_fsm #(.WINDOW_LEN(WINDOW_LEN), .DLY_W(DLY_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wpos     (wpos),
        .wlast    (wlast),
        .etick    (etick),
        .delay_in (delay_in),
        .stall    (stall)
    );

    assign dn_valid   = up_valid && !stall;
    assign up_ready   = dn_ready && !stall;
    assign dn_cmd     = up_cmd;
    assign stall_o    = stall;
    assign epoch_tick = etick;

    assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (!dn_valid && !up_ready));

    assert_no_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready) == (dn_valid && dn_ready));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!stall_o && !epoch_tick));

endmodule

// File: tb/tb_mem_throttle_gate.sv
`timescale 1ns/1ps
module tb_mem_throttle_gate;

    localparam int W     = 20;
    localparam int E     = 130;
    localparam int DLY_W = 16;
    localparam int CMD_W = 32;
    localparam int RUN   = 4000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DLY_W-1:0] delay_in = '0;
    logic             up_valid = 1'b0;
    logic             up_ready;
    logic [CMD_W-1:0] up_cmd = '0;
    logic             dn_valid;
    logic             dn_ready = 1'b0;
    logic [CMD_W-1:0] dn_cmd;
    logic             stall_o;
    logic             epoch_tick;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mem_throttle_gate #(
        .WINDOW_LEN(W), .EPOCH_LEN(E), .DLY_W(DLY_W), .CMD_W(CMD_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .delay_in(delay_in),
        .up_valid(up_valid), .up_ready(up_ready), .up_cmd(up_cmd),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_cmd(dn_cmd),
        .stall_o(stall_o), .epoch_tick(epoch_tick)
    );

    function automatic int clamp_t(int d);
        return (d >= W) ? W - 1 : d;
    endfunction

    function automatic bit exp_stall(int pos, int t);
        return (pos + t) >= W;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // model state
    int m_w = 0, m_e = 0, m_t = 0;
    bit m_pend = 1'b1;
    int loads = 0;
    int up_xfer = 0, dn_xfer = 0;
    bit seen_zero = 0, seen_clamp = 0, seen_max = 0;

    function automatic int directed(int k);
        case (k)
            0: return 0;
            1: return 5;
            2: return 25;
            3: return 20;
            4: return 19;
            5: return 65535;
            6: return 0;
            default: return $urandom % 30;
        endcase
    endfunction

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        #1;
        chk("R1 stall in reset", stall_o, 0);
        chk("R1 tick in reset", epoch_tick, 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int n = 0; n < RUN; n++) begin
            #1;
            // compare outputs for cycle n
            if (n == 0) begin
                chk("R1 stall at release", stall_o, 0);
                chk("R1 tick at release", epoch_tick, 0);
            end
            if (n < W) chk("R1 first window open", stall_o, 0);
            chk("R2 stall position", stall_o, exp_stall(m_w, m_t));
            if (m_t == 0) chk("R8 zero delay no stall", stall_o, 0);
            if (m_w == 0) chk("R4 window starts open", stall_o, 0);
            chk("R7 epoch tick", epoch_tick, (m_e == E - 1));
            if (stall_o) begin
                chk("R5 dn_valid blocked", dn_valid, 0);
                chk("R5 up_ready blocked", up_ready, 0);
            end else begin
                chk("R6 dn_valid pass", dn_valid, up_valid);
                chk("R6 up_ready pass", up_ready, dn_ready);
            end
            checks++;
            if (dn_cmd !== up_cmd) begin
                failures++;
                $display("FAIL R6 dn_cmd actual=%0h expected=%0h", dn_cmd, up_cmd);
            end
            if (up_valid && up_ready) up_xfer++;
            if (dn_valid && dn_ready) dn_xfer++;
            chk("R9 transfer count", dn_xfer, up_xfer);
            if (m_t == 0) seen_zero = 1;
            if (m_t == W - 1) seen_max = 1;

            // advance model with inputs of cycle n
            if (m_e == E - 1) m_pend = 1'b1;
            if (m_w == W - 1 && m_pend) begin
                m_t = clamp_t(int'(delay_in));
                if (int'(delay_in) >= W) seen_clamp = 1;
                m_pend = 1'b0;
                loads++;
            end
            m_w = (m_w + 1) % W;
            m_e = (m_e + 1) % E;

            // drive inputs for cycle n+1
            @(negedge clk);
            up_valid = 1'($urandom);
            dn_ready = ($urandom % 4) != 0;
            up_cmd   = $urandom;
            if (m_w == W - 1)
                delay_in = DLY_W'(directed(loads));
            else
                delay_in = DLY_W'($urandom);   // ignored off the boundary (R3)
        end
        chk("R4 clamp case reached", int'(seen_clamp), 1);
        chk("R4 max delay reached", int'(seen_max), 1);
        chk("R8 zero delay reached", int'(seen_zero), 1);
        chk("R3 load count", loads, 1 + (RUN - 1) / E);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #((RUN + 200) * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule